// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the pixel coordinate of the current position inside the visible window. Timing is not set as separate porch widths. It is set as cumulative boundaries, each one less than the running total. These are the end of sync, the end of back porch, the end of active video and the last count of the line or frame. Each boundary is compared directly against a free-running counter. A horizontal counter advances on every pixel clock. A vertical counter advances once per line, when the horizontal counter wraps.

Each of the three strobes has its own polarity select. A separate select chooses whether the pixel clock leaves the block in phase or inverted, so that data is launched on the rising or the falling edge. Inside the visible window the colour output carries the upstream layer colour when a layer covers the pixel. When no layer covers it, the output carries a programmable background colour. A global enable starts the generator, and the enable state is reported back on an output.

Top module: `lcd_timing_gen`

## Requirements
- R1: While enabled, the horizontal counter steps by one per clock from 0 up to `h_total_i` and then returns to 0. `x_o` equals the counter minus `h_bp_acc_i` minus 1 while data enable is active, and is 0 otherwise.
- R2: The vertical counter advances only in the clock where the horizontal counter wraps. It returns to 0 after `v_total_i`. `y_o` equals the vertical counter minus `v_bp_acc_i` minus 1 while data enable is active, and is 0 otherwise.
- R3: Horizontal sync is asserted while the horizontal counter is at most `h_sync_w_i`. Vertical sync is asserted while the vertical counter is at most `v_sync_w_i`. A width value of 0 gives a sync pulse of one count.
- R4: Data enable is asserted only when the horizontal counter is greater than `h_bp_acc_i` and at most `h_act_acc_i`, and the vertical counter is greater than `v_bp_acc_i` and at most `v_act_acc_i`.
- R5: `vblank_o` is 1 while enabled and the vertical counter lies outside the vertical active range of R4.
- R6: For each of hsync, vsync and data enable, a polarity input of 1 drives the pin high when the strobe is asserted, and a polarity input of 0 drives it low when asserted. The inactive level is the opposite.
- R7: `pclk_o` equals `clk_i` when `pclk_pol_i` is 1, and equals the inverse of `clk_i` when it is 0.
- R8: While data enable is asserted, `rgb_o` is `layer_rgb_i` if `layer_hit_i` is 1 and `bg_rgb_i` otherwise. Both colours are packed as {red[23:16], green[15:8], blue[7:0]}. Outside data enable, `rgb_o` is 0.
- R9: `en_o` shows the value of `en_i` registered at the previous clock edge. Counting begins one clock after `en_o` rises.
- R10: While `en_o` is 0, the counters are cleared on the next edge. Sync and data enable sit at their inactive levels, and `vblank_o`, `x_o`, `y_o` and `rgb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable request |
| h_sync_w_i | input | 12 | Horizontal sync width minus 1 |
| h_bp_acc_i | input | 12 | Sync plus back porch minus 1, horizontal |
| h_act_acc_i | input | 12 | Sync plus back porch plus active width minus 1 |
| h_total_i | input | 12 | Last horizontal count of a line |
| v_sync_w_i | input | 12 | Vertical sync height minus 1 |
| v_bp_acc_i | input | 12 | Sync plus back porch minus 1, vertical |
| v_act_acc_i | input | 12 | Sync plus back porch plus active height minus 1 |
| v_total_i | input | 12 | Last line count of a frame |
| hs_pol_i | input | 1 | Hsync polarity, 1 = active high |
| vs_pol_i | input | 1 | Vsync polarity, 1 = active high |
| de_pol_i | input | 1 | Data enable polarity, 1 = active high |
| pclk_pol_i | input | 1 | Pixel clock output phase, 1 = in phase |
| bg_rgb_i | input | 24 | Background colour |
| layer_hit_i | input | 1 | A layer covers the current pixel |
| layer_rgb_i | input | 24 | Colour from the layer stage |
| en_o | output | 1 | Enable readback |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data enable pin |
| vblank_o | output | 1 | Vertical blanking flag |
| x_o | output | 12 | Column inside the active area |
| y_o | output | 12 | Row inside the active area |
| rgb_o | output | 24 | Pixel colour to the panel |

## Verification
The hardest situation to reach is disabling the generator partway through a visible line and then restarting it with a different geometry. In that case the counters must restart from zero, and the one cycle in which `en_o` has dropped but the counters still hold old values must not leak to the pins. The stimulus turns the enable off in the middle of an active line, runs a stretch while disabled, and reprograms every boundary, including a sync width of 0. It then re-enables and runs several full frames. A cycle-accurate behavioural model in the bench is compared against every output on every clock throughout, while all four polarity bits and the layer-hit input are varied.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned AXES = 2;
  localparam int unsigned AX_H = 0;
  localparam int unsigned AX_V = 1;
  localparam int unsigned CH_W = 8;
  localparam int unsigned RGB_W = 3 * CH_W;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          step_i,
  input  logic [CW-1:0] sync_w_i,
  input  logic [CW-1:0] bp_acc_i,
  input  logic [CW-1:0] act_acc_i,
  input  logic [CW-1:0] total_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          sync_o,
  output logic          act_o,
  output logic [CW-1:0] pos_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = (cnt_q == total_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign sync_o = (cnt_q <= sync_w_i);
  assign act_o  = (cnt_q > bp_acc_i) && (cnt_q <= act_acc_i);
  assign pos_o  = cnt_q - bp_acc_i - 1'b1;
endmodule

// File: rtl/lcd_tg_out.sv
module lcd_tg_out #(
  parameter int unsigned CW    = 12,
  parameter int unsigned RGB_W = 24
) (
  input  logic             en_i,
  input  logic             hs_raw_i,
  input  logic             vs_raw_i,
  input  logic             h_act_i,
  input  logic             v_act_i,
  input  logic [CW-1:0]    h_pos_i,
  input  logic [CW-1:0]    v_pos_i,
  input  logic             hs_pol_i,
  input  logic             vs_pol_i,
  input  logic             de_pol_i,
  input  logic [RGB_W-1:0] bg_rgb_i,
  input  logic             layer_hit_i,
  input  logic [RGB_W-1:0] layer_rgb_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             vblank_o,
  output logic [CW-1:0]    x_o,
  output logic [CW-1:0]    y_o,
  output logic [RGB_W-1:0] rgb_o
);
  logic hs_on, vs_on, de_on;

  assign hs_on = en_i & hs_raw_i;
  assign vs_on = en_i & vs_raw_i;
  assign de_on = en_i & h_act_i & v_act_i;

  // pin level = polarity when asserted, its inverse when idle
  assign hsync_o  = hs_on ? hs_pol_i : ~hs_pol_i;
  assign vsync_o  = vs_on ? vs_pol_i : ~vs_pol_i;
  assign de_o     = de_on ? de_pol_i : ~de_pol_i;
  assign vblank_o = en_i & ~v_act_i;

  always_comb begin
    x_o   = '0;
    y_o   = '0;
    rgb_o = '0;
    if (de_on) begin
      x_o   = h_pos_i;
      y_o   = v_pos_i;
      rgb_o = layer_hit_i ? layer_rgb_i : bg_rgb_i;
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CW-1:0]    h_sync_w_i,
  input  logic [CW-1:0]    h_bp_acc_i,
  input  logic [CW-1:0]    h_act_acc_i,
  input  logic [CW-1:0]    h_total_i,
  input  logic [CW-1:0]    v_sync_w_i,
  input  logic [CW-1:0]    v_bp_acc_i,
  input  logic [CW-1:0]    v_act_acc_i,
  input  logic [CW-1:0]    v_total_i,
  input  logic             hs_pol_i,
  input  logic             vs_pol_i,
  input  logic             de_pol_i,
  input  logic             pclk_pol_i,
  input  logic [RGB_W-1:0] bg_rgb_i,
  input  logic             layer_hit_i,
  input  logic [RGB_W-1:0] layer_rgb_i,
  output logic             en_o,
  output logic             pclk_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             vblank_o,
  output logic [CW-1:0]    x_o,
  output logic [CW-1:0]    y_o,
  output logic [RGB_W-1:0] rgb_o
);
  logic          en_q;
  logic [CW-1:0] sync_w [AXES];
  logic [CW-1:0] bp_acc [AXES];
  logic [CW-1:0] act_acc[AXES];
  logic [CW-1:0] total  [AXES];
  logic [CW-1:0] cnt    [AXES];
  logic [CW-1:0] pos    [AXES];
  logic [AXES-1:0] step, wrap, sync_raw, act_raw;
  logic [CW-1:0] h_cnt, v_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end
  assign en_o = en_q;

  assign sync_w[AX_H]  = h_sync_w_i;
  assign bp_acc[AX_H]  = h_bp_acc_i;
  assign act_acc[AX_H] = h_act_acc_i;
  assign total[AX_H]   = h_total_i;
  assign sync_w[AX_V]  = v_sync_w_i;
  assign bp_acc[AX_V]  = v_bp_acc_i;
  assign act_acc[AX_V] = v_act_acc_i;
  assign total[AX_V]   = v_total_i;

  // horizontal runs every clock, vertical on horizontal wrap
  assign step[AX_H] = 1'b1;
  assign step[AX_V] = wrap[AX_H];

  for (genvar gi = 0; gi < AXES; gi++) begin : g_axis
    lcd_tg_axis #(.CW(CW)) u_axis (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (en_q),
      .step_i   (step[gi]),
      .sync_w_i (sync_w[gi]),
      .bp_acc_i (bp_acc[gi]),
      .act_acc_i(act_acc[gi]),
      .total_i  (total[gi]),
      .cnt_o    (cnt[gi]),
      .wrap_o   (wrap[gi]),
      .sync_o   (sync_raw[gi]),
      .act_o    (act_raw[gi]),
      .pos_o    (pos[gi])
    );
  end

  assign h_cnt = cnt[AX_H];
  assign v_cnt = cnt[AX_V];

  lcd_tg_out #(.CW(CW), .RGB_W(RGB_W)) u_out (
    .en_i       (en_q),
    .hs_raw_i   (sync_raw[AX_H]),
    .vs_raw_i   (sync_raw[AX_V]),
    .h_act_i    (act_raw[AX_H]),
    .v_act_i    (act_raw[AX_V]),
    .h_pos_i    (pos[AX_H]),
    .v_pos_i    (pos[AX_V]),
    .hs_pol_i   (hs_pol_i),
    .vs_pol_i   (vs_pol_i),
    .de_pol_i   (de_pol_i),
    .bg_rgb_i   (bg_rgb_i),
    .layer_hit_i(layer_hit_i),
    .layer_rgb_i(layer_rgb_i),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .de_o       (de_o),
    .vblank_o   (vblank_o),
    .x_o        (x_o),
    .y_o        (y_o),
    .rgb_o      (rgb_o)
  );

  assign pclk_o = pclk_pol_i ? clk_i : ~clk_i;
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          en_o,
  input logic [CW-1:0] h_cnt,
  input logic [CW-1:0] v_cnt,
  input logic [CW-1:0] h_total_i,
  input logic          hs_pol_i,
  input logic          vs_pol_i,
  input logic          de_pol_i,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic          vblank_o,
  input logic [23:0]   rgb_o
);
  AST_H_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o && h_cnt != h_total_i |=> h_cnt == $past(h_cnt) + 1'b1); // R1
  AST_H_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o && h_cnt == h_total_i |=> h_cnt == '0); // R1
  AST_V_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o && h_cnt != h_total_i |=> $stable(v_cnt)); // R2
  AST_EN_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> en_o == $past(en_i)); // R9
  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> hsync_o != hs_pol_i && vsync_o != vs_pol_i && de_o != de_pol_i && !vblank_o); // R10
  AST_DIS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> h_cnt == '0 && v_cnt == '0); // R10
  AST_RGB_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o != de_pol_i |-> rgb_o == '0); // R8
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .en_o     (en_o),
  .h_cnt    (h_cnt),
  .v_cnt    (v_cnt),
  .h_total_i(h_total_i),
  .hs_pol_i (hs_pol_i),
  .vs_pol_i (vs_pol_i),
  .de_pol_i (de_pol_i),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .de_o     (de_o),
  .vblank_o (vblank_o),
  .rgb_o    (rgb_o)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  localparam int CW = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic [CW-1:0] h_sync_w_i, h_bp_acc_i, h_act_acc_i, h_total_i;
  logic [CW-1:0] v_sync_w_i, v_bp_acc_i, v_act_acc_i, v_total_i;
  logic hs_pol_i, vs_pol_i, de_pol_i, pclk_pol_i, layer_hit_i;
  logic [23:0] bg_rgb_i, layer_rgb_i;
  logic en_o, pclk_o, hsync_o, vsync_o, de_o, vblank_o;
  logic [CW-1:0] x_o, y_o;
  logic [23:0] rgb_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_h = 0, m_v = 0;
  bit m_en = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk_i = ~clk_i;

  lcd_timing_gen #(.CW(CW)) uut (.*);

  // behavioural reference: counter state after each edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_h = 0; m_v = 0; m_en = 0;
    end else begin
      if (!m_en) begin
        m_h = 0; m_v = 0;
      end else if (m_h == int'(h_total_i)) begin
        m_h = 0;
        m_v = (m_v == int'(v_total_i)) ? 0 : m_v + 1;
      end else begin
        m_h = m_h + 1;
      end
      m_en = en_i;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    bit hs, vs, ha, va, de;
    int ex, ey, ergb;
    cyc++;
    hs = m_en && m_h <= int'(h_sync_w_i);
    vs = m_en && m_v <= int'(v_sync_w_i);
    ha = m_h > int'(h_bp_acc_i) && m_h <= int'(h_act_acc_i);
    va = m_v > int'(v_bp_acc_i) && m_v <= int'(v_act_acc_i);
    de = m_en && ha && va;
    ex = de ? m_h - int'(h_bp_acc_i) - 1 : 0;
    ey = de ? m_v - int'(v_bp_acc_i) - 1 : 0;
    ergb = de ? int'(layer_hit_i ? layer_rgb_i : bg_rgb_i) : 0;
    chk("R9", "en_o", int'(en_o), int'(m_en));
    chk("R3_R6", "hsync_o", int'(hsync_o), int'(hs ? hs_pol_i : !hs_pol_i));
    chk("R3_R6", "vsync_o", int'(vsync_o), int'(vs ? vs_pol_i : !vs_pol_i));
    chk("R4_R6", "de_o", int'(de_o), int'(de ? de_pol_i : !de_pol_i));
    chk("R5", "vblank_o", int'(vblank_o), int'(m_en && !va));
    chk("R1", "x_o", int'(x_o), ex);
    chk("R2", "y_o", int'(y_o), ey);
    chk("R8", "rgb_o", int'(rgb_o), ergb);
    chk("R7", "pclk_o low phase", int'(pclk_o), int'(!pclk_pol_i));
    if (!m_en) chk("R10", "idle x/y/rgb", int'(x_o) | int'(y_o) | int'(rgb_o), 0);
    // next pseudo-random layer pattern
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    layer_hit_i = lfsr[0];
    layer_rgb_i = {lfsr[7:0], lfsr[15:8], lfsr[11:4]};
  end

  // high-phase check of the pixel clock output
  always @(posedge clk_i) begin
    #5;
    chk("R7", "pclk_o high phase", int'(pclk_o), int'(pclk_pol_i));
  end

  task automatic set_geom(input int hs, input int hbp, input int ha, input int hfp,
                          input int vs, input int vbp, input int va, input int vfp);
    h_sync_w_i  = CW'(hs - 1);
    h_bp_acc_i  = CW'(hs + hbp - 1);
    h_act_acc_i = CW'(hs + hbp + ha - 1);
    h_total_i   = CW'(hs + hbp + ha + hfp - 1);
    v_sync_w_i  = CW'(vs - 1);
    v_bp_acc_i  = CW'(vs + vbp - 1);
    v_act_acc_i = CW'(vs + vbp + va - 1);
    v_total_i   = CW'(vs + vbp + va + vfp - 1);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    set_geom(2, 2, 4, 2, 1, 1, 3, 1);
    {hs_pol_i, vs_pol_i, de_pol_i, pclk_pol_i} = 4'b1111;
    bg_rgb_i = 24'h000000;
    layer_hit_i = 0;
    layer_rgb_i = '0;
    run(3);                       // R10 reset state compared each cycle
    rst_ni = 1'b1;
    run(4);
    en_i = 1'b1;                  // R9 start, R1..R8 active-high
    run(150);
    bg_rgb_i = 24'h102030;
    {hs_pol_i, vs_pol_i, de_pol_i, pclk_pol_i} = 4'b0000; // R6 R7 active-low
    run(140);
    while (!(m_en && m_h > int'(h_bp_acc_i) && m_v > int'(v_bp_acc_i) && m_v <= int'(v_act_acc_i)))
      run(1);
    en_i = 1'b0;                  // R10 drop mid-line
    run(20);
    set_geom(1, 3, 7, 1, 2, 2, 5, 2); // sync width 1 count, R3
    {hs_pol_i, vs_pol_i, de_pol_i, pclk_pol_i} = 4'b1010;
    bg_rgb_i = 24'hFF00A5;
    en_i = 1'b1;
    run(600);
    {hs_pol_i, vs_pol_i, de_pol_i, pclk_pol_i} = 4'b0101;
    run(400);
    en_i = 1'b0;
    run(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule